// File: doc/BRIEF.md
# Reloadable Baud Tick Generator

This block produces the timing pulse a serial port uses for its bit or oversample clock. The system clock passes through a prescaler that divides by 1, 4, 12 or 48, selected by a 2-bit field. Each prescaled step advances a 16-bit up-counter. When the counter steps past its all-ones value it does not fall to zero. It restarts from a programmable start value and raises a one-cycle tick. The tick period is therefore divide × (65536 − start value) system clocks.

The start value is written a byte at a time. The high byte waits in a holding register. Writing the low byte commits both halves at once into a pending start value. The counter takes up the pending value only at an overflow or when the generator is enabled, so a half-written value never reaches the count. An enable input gates the whole generator. Periods faster than one sixteenth of the system clock still count correctly, but they are not suitable for a receiver.

A small controller sequences the generator through three states:
- ST_IDLE is the disabled state.
- ST_LOAD is a single cycle that copies the pending start value into the counter and clears the prescaler.
- ST_RUN is the counting state.

The transitions are:
- ST_IDLE → ST_LOAD when enable is seen high.
- ST_LOAD → ST_RUN unconditionally, provided enable is still high.
- ST_RUN → ST_IDLE, and ST_LOAD → ST_IDLE, whenever enable is seen low.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, tick_o is 0 and stays 0 until the generator is enabled.
- R2: While enable_i is low, no tick is produced, however long the generator is held off.
- R3: With enable_i high, consecutive ticks are exactly D × (65536 − V) clock cycles apart. V is the committed start value. D is 1, 4, 12 or 48 for presc_sel_i = 0, 1, 2 or 3.
- R4: Counting clock edges from the first edge that samples enable_i high (edge 1), the first tick is visible after edge D × (65536 − V) + 2.
- R5: Whenever the tick period exceeds one cycle, tick_o is high for exactly one cycle per overflow.
- R6: A write with hi_we_i stores reload_byte_i as the high byte in a holding register only. A write with lo_we_i commits {held high byte, reload_byte_i} as the pending start value. A high-byte write without a following low-byte write leaves the period unchanged.
- R7: A start value committed in mid-period does not alter the period in progress. It takes effect from the next overflow onward.
- R8: A change of presc_sel_i spends one clock restarting the prescaler, with no count step in that clock. The period that spans the change is therefore N + 1 cycles when switching to divide-by-1 just after a tick, where N = 65536 − V.
- R9: Dropping enable_i in mid-period and raising it again restarts counting from the pending start value, with the full R4 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Generator enable |
| presc_sel_i | input | 2 | Prescaler select: 0 → /1, 1 → /4, 2 → /12, 3 → /48 |
| hi_we_i | input | 1 | Write strobe for the high byte of the start value |
| lo_we_i | input | 1 | Write strobe for the low byte; commits the full start value |
| reload_byte_i | input | 8 | Start value byte being written |
| tick_o | output | 1 | One-cycle pulse on each counter overflow |

## Verification
The main timing is swept over all four divides crossed with start values 0xFFFF, 0xFFFE, 0xFFF0 and 0xFFC3. Each combination is measured for first-tick latency and for several back-to-back periods.
- The latency and period checks separate a wrong divide ratio from an off-by-one in the wrap or load logic.
- The 0xFFFF case exposes any extra dead cycle at the wrap.
- Separate patterns rewrite the start value in mid-period, and write only the high byte. These tell a correctly double-buffered start value apart from one applied at once or torn.
- Switching the select just after a tick distinguishes a restarted prescaler from one that keeps a stale partial count.
- A mid-period disable and re-enable checks that counting restarts from the start value rather than resuming.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_e;

    localparam int NUM_DIV = 4;
    localparam int MAX_DIV = 48;
    localparam int PRE_W   = $clog2(MAX_DIV);

    // divide ratio chosen by each select code
    function automatic int unsigned div_of(input int unsigned sel);
        case (sel)
            0:       return 1;
            1:       return 4;
            2:       return 12;
            default: return 48;
        endcase
    endfunction

endpackage

// File: rtl/baud_presc.sv
module baud_presc
    import baud_tick_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] sel_i,
    output logic [1:0] sel_q_o,
    output logic       step_o
);

    logic [PRE_W-1:0]   pre_cnt;
    logic [NUM_DIV-1:0] at_end;
    logic               sel_chg;

    genvar g;
    generate
        for (g = 0; g < NUM_DIV; g++) begin : g_term
            localparam int unsigned TERM = div_of(g) - 1;
            assign at_end[g] = (pre_cnt == PRE_W'(TERM));
        end
    endgenerate

    assign sel_chg = (sel_i != sel_q_o);
    assign step_o  = run_i && !sel_chg && at_end[sel_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            sel_q_o <= '0;
        end else begin
            sel_q_o <= sel_i;
            if (!run_i || sel_chg || at_end[sel_i])
                pre_cnt <= '0;
            else
                pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/baud_reload_buf.sv
module baud_reload_buf #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_we_i,
    input  logic              lo_we_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [CNT_W-1:0]  reload_o
);

    logic [BYTE_W-1:0] hi_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_hold  <= '0;
            reload_o <= '0;
        end else begin
            if (hi_we_i)
                hi_hold <= byte_i;
            if (lo_we_i)
                reload_o <= {hi_hold, byte_i};
        end
    end

endmodule

// File: rtl/baud_ctrl_fsm.sv
module baud_ctrl_fsm
    import baud_tick_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] reload_i,
    output gen_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             tick_o
);

    gen_state_e state_d;
    logic       wrap;

    assign wrap  = (cnt_o == {CNT_W{1'b1}});
    assign run_o = (state_o == ST_RUN) && enable_i;

    // next-state logic
    always_comb begin
        state_d = state_o;
        unique case (state_o)
            ST_IDLE: if (enable_i)  state_d = ST_LOAD;
            ST_LOAD: state_d = enable_i ? ST_RUN : ST_IDLE;
            ST_RUN:  if (!enable_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_o <= ST_IDLE;
        else
            state_o <= state_d;
    end

    // counter and tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= 1'b0;
            unique case (state_o)
                ST_IDLE: ;
                ST_LOAD: if (enable_i) cnt_o <= reload_i;
                ST_RUN: begin
                    if (run_o && step_i) begin
                        if (wrap) begin
                            cnt_o  <= reload_i;
                            tick_o <= 1'b1;
                        end else begin
                            cnt_o <= cnt_o + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [1:0]        presc_sel_i,
    input  logic              hi_we_i,
    input  logic              lo_we_i,
    input  logic [BYTE_W-1:0] reload_byte_i,
    output logic              tick_o
);

    gen_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload_q;
    logic [1:0]       sel_q;
    logic             run;
    logic             step;

    baud_reload_buf #(.BYTE_W(BYTE_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_we_i  (hi_we_i),
        .lo_we_i  (lo_we_i),
        .byte_i   (reload_byte_i),
        .reload_o (reload_q)
    );

    baud_presc u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .sel_i   (presc_sel_i),
        .sel_q_o (sel_q),
        .step_o  (step)
    );

    baud_ctrl_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .step_i   (step),
        .reload_i (reload_q),
        .state_o  (state),
        .cnt_o    (cnt),
        .run_o    (run),
        .tick_o   (tick_o)
    );

endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk
    import baud_tick_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_i,
    input logic [1:0]       sel_i,
    input logic [1:0]       sel_q,
    input logic             step,
    input gen_state_e       state,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload_q,
    input logic             tick_o
);

    assert_no_tick_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !tick_o);

    assert_wrap_reloads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == {CNT_W{1'b1}}) |=> (tick_o && cnt == $past(reload_q)));

    assert_step_increments_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt != {CNT_W{1'b1}}) |=> (!tick_o && cnt == $past(cnt) + 1'b1));

    assert_hold_without_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !step) |=> ($stable(cnt) && !tick_o));

    assert_sel_change_no_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i != sel_q) |-> !step);

    assert_load_takes_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && enable_i) |=> (state == ST_RUN && cnt == $past(reload_q)));

    assert_idle_no_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> !step);

endmodule

bind baud_tick_gen baud_tick_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable_i),
    .sel_i    (presc_sel_i),
    .sel_q    (sel_q),
    .step     (step),
    .state    (state),
    .cnt      (cnt),
    .reload_q (reload_q),
    .tick_o   (tick_o)
);

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 20000;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0;
    logic [1:0] presc_sel_i = 2'd0;
    logic       hi_we_i = 1'b0;
    logic       lo_we_i = 1'b0;
    logic [7:0] reload_byte_i = 8'd0;
    logic       tick_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    baud_tick_gen u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (enable_i),
        .presc_sel_i   (presc_sel_i),
        .hi_we_i       (hi_we_i),
        .lo_we_i       (lo_we_i),
        .reload_byte_i (reload_byte_i),
        .tick_o        (tick_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    function automatic int divv(input int sel);
        case (sel)
            0: return 1;
            1: return 4;
            2: return 12;
            default: return 48;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // count clock edges until tick_o is seen high, starting from 'start'
    task automatic measure(input int start, output int cycles);
        cycles = start;
        do begin
            @(posedge clk);
            @(negedge clk);
            cycles++;
        end while (!tick_o && cycles < LIMIT);
    endtask

    // commit a start value: high byte then low byte (two cycles)
    task automatic write_reload(input logic [15:0] v);
        hi_we_i = 1'b1; reload_byte_i = v[15:8];
        @(negedge clk);
        hi_we_i = 1'b0; lo_we_i = 1'b1; reload_byte_i = v[7:0];
        @(negedge clk);
        lo_we_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    logic [15:0] vals [4] = '{16'hFFFF, 16'hFFFE, 16'hFFF0, 16'hFFC3};

    initial begin
        int m;
        int seen;
        int nn;
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset tick", int'(tick_o), 0);

        // R1/R2: stay disabled, never a tick
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tick_o) seen++;
        end
        check("R2 ticks while disabled", seen, 0);

        // R3/R4/R5 sweep: all divides x several start values
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 4; v++) begin
                enable_i = 1'b0;
                presc_sel_i = 2'(s);
                write_reload(vals[v]);
                idle(2);
                nn = 65536 - int'(vals[v]);
                d = divv(s);
                enable_i = 1'b1;
                measure(0, m);
                check($sformatf("R4 latency sel%0d v%h", s, vals[v]), m, d * nn + 2);
                for (int k = 0; k < 3; k++) begin
                    measure(0, m);
                    check($sformatf("R3 period sel%0d v%h", s, vals[v]), m, d * nn);
                end
                if (d * nn > 1) begin
                    @(negedge clk);
                    check($sformatf("R5 pulse width sel%0d v%h", s, vals[v]), int'(tick_o), 0);
                end
            end
        end

        // R2: disable after running, check silence
        enable_i = 1'b0;
        @(negedge clk);
        seen = 0;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (tick_o) seen++;
        end
        check("R2 ticks after disable", seen, 0);

        // R7: mid-period commit, divide 4, 0xFFF0 -> 0xFFF8
        presc_sel_i = 2'd1;
        write_reload(16'hFFF0);
        idle(2);
        enable_i = 1'b1;
        measure(0, m);
        check("R4 latency before R7", m, 4 * 16 + 2);
        idle(3);
        write_reload(16'hFFF8);
        measure(5, m);
        check("R7 current period unchanged", m, 64);
        measure(0, m);
        check("R7 new period applied", m, 32);

        // R6: high byte alone does not change the period
        hi_we_i = 1'b1; reload_byte_i = 8'hAA;
        @(negedge clk);
        hi_we_i = 1'b0;
        measure(1, m);
        check("R6 hi-only period (span)", m, 32);
        measure(0, m);
        check("R6 hi-only period", m, 32);
        // R6: low byte now commits {0xAA held? no: rewrite high first} -> FFFC
        write_reload(16'hFFFC);
        measure(2, m);
        check("R6 period during commit", m, 32);
        measure(0, m);
        check("R6 committed value", m, 16);

        // R8: switch divide 48 -> 1 right after a tick
        enable_i = 1'b0;
        presc_sel_i = 2'd3;
        write_reload(16'hFFF0);
        idle(2);
        enable_i = 1'b1;
        measure(0, m);
        check("R4 latency before R8", m, 48 * 16 + 2);
        presc_sel_i = 2'd0;
        measure(0, m);
        check("R8 period across select change", m, 17);
        measure(0, m);
        check("R8 period after select change", m, 16);

        // R9: disable mid-period then re-enable restarts from start value
        presc_sel_i = 2'd2;
        idle(3);
        measure(0, m);
        idle(40);
        enable_i = 1'b0;
        idle(3);
        enable_i = 1'b1;
        measure(0, m);
        check("R9 latency after re-enable", m, 12 * 16 + 2);
        measure(0, m);
        check("R9 period after re-enable", m, 12 * 16);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule